// File: doc/BRIEF.md
# Serial Byte Transmitter with Parity and Programmable CRC Trailer

This block sends one byte per frame on a single serial line. A load strobe takes the byte on the data input into a holding register, together with an 8-bit CRC divisor value. On the next cycle the frame is built in a shift register. Each shift tick then puts one bit on the line. The frame is sent in this order: a low start bit, the eight data bits least significant first, an even parity bit, the eight-bit CRC remainder most significant first, and finally a high stop bit.

The CRC divisor is given at run time as the low eight coefficients of a degree-8 polynomial. The x^8 term is implied and is not part of the input. Busy stays high from the accepted load until the tick that ends the stop bit. The shift tick comes from outside the block, normally from a baud divider, and can be any strobe one clock cycle long.

Top module: `crc_frame_tx`

## Requirements
- R1: After reset, tx_o is 1 and busy_o is 0. Whenever busy_o is 0, tx_o is 1.
- R2: A load_i pulse while busy_o is 0 captures data_i and divisor_i, and busy_o is 1 in the next cycle.
- R3: The first shift tick after a capture drives tx_o to 0 (start bit). A tick that arrives in the cycle right after the capture is ignored.
- R4: The next eight ticks drive data bits 0 through 7 in that order, one bit per tick.
- R5: The tenth tick drives the even parity bit, which equals the XOR of the eight data bits.
- R6: Ticks 11 to 18 drive the CRC remainder, most significant bit first. The remainder is (data · x^8) mod (x^8 + Σ divisor[i]·x^i), where data bit 7 is the coefficient of x^7.
- R7: Tick 19 drives the stop bit, which is 1.
- R8: busy_o stays 1 through tick 19 and falls in the cycle after tick 20. tx_o is still 1 at that point.
- R9: A load_i pulse while busy_o is 1 has no effect. This includes the cycle of tick 20, and the frame in progress continues unchanged.
- R10: Changing divisor_i or data_i after the capture does not affect the frame in progress.
- R11: tx_o changes only in the cycle after a cycle in which shift_i was high. Ticks while idle leave tx_o at 1 and busy_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Capture strobe for the data byte and the divisor |
| data_i | input | 8 | Byte to send |
| divisor_i | input | 8 | Low coefficients of the CRC polynomial; the x^8 term is implied |
| shift_i | input | 1 | One-cycle tick that advances the line by one bit |
| tx_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | High while a frame is in progress |

## Verification
A load request and the tick that ends the frame can fall in the same clock cycle. The bench raises load_i together with the 20th shift tick and checks two things: busy_o falls anyway, and no new frame starts (the line stays high through later ticks). A load with different data and a different divisor, given in the middle of a frame, is checked in the same way. Every remaining bit of that frame must still match the values computed from the original capture.

// File: rtl/crc_frame_tx.sv
module crc_frame_tx #(
  parameter int DATA_W = 8,
  parameter int CRC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CRC_W-1:0]  divisor_i,
  input  logic              shift_i,
  output logic              tx_o,
  output logic              busy_o
);
  localparam int FRAME_BITS = DATA_W + CRC_W + 3;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);

  logic [DATA_W-1:0]     hold_data;
  logic [CRC_W-1:0]      hold_div;
  logic [FRAME_BITS-1:0] sreg;
  logic [CNT_W-1:0]      cnt;
  logic                  pend;
  logic                  busy_q;
  logic                  tx_q;

  function automatic logic [CRC_W-1:0] crc_of(input logic [DATA_W-1:0] d,
                                               input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] r;
    r = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (r[CRC_W-1] ^ d[i]) r = (r << 1) ^ poly;
      else                   r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [CRC_W-1:0] flip(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] o;
    for (int i = 0; i < CRC_W; i++) o[i] = v[CRC_W-1-i];
    return o;
  endfunction

  wire accept  = load_i && !busy_q;
  wire advance = shift_i && busy_q && !pend;
  wire last    = (cnt == CNT_W'(FRAME_BITS));
  wire parity  = ^hold_data;
  wire [CRC_W-1:0] rem = crc_of(hold_data, hold_div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_data <= '0;
      hold_div  <= '0;
      sreg      <= '1;
      cnt       <= '0;
      pend      <= 1'b0;
      busy_q    <= 1'b0;
      tx_q      <= 1'b1;
    end else begin
      if (accept) begin
        hold_data <= data_i;
        hold_div  <= divisor_i;
        busy_q    <= 1'b1;
        pend      <= 1'b1;
        cnt       <= '0;
      end else if (pend) begin
        sreg <= {1'b1, flip(rem), parity, hold_data, 1'b0};
        pend <= 1'b0;
      end else if (advance) begin
        if (last) begin
          busy_q <= 1'b0;
          cnt    <= '0;
        end else begin
          tx_q <= sreg[0];
          sreg <= {1'b1, sreg[FRAME_BITS-1:1]};
          cnt  <= cnt + 1'b1;
        end
      end
    end
  end

  assign tx_o   = tx_q;
  assign busy_o = busy_q;

  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> tx_o);
  a_r2_load_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !busy_o) |=> busy_o);
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !pend && cnt == '0 && shift_i) |=> !tx_o);
  a_r8_busy_ends_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> ($past(shift_i) && tx_o));
  a_r9_hold_kept_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(hold_data) || !$past(busy_o)));
  a_r10_divisor_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !load_i) |=> $stable(hold_div));
  a_r11_tx_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_i |=> $stable(tx_o));
endmodule

// File: tb/crc_frame_tx_tb.sv
module crc_frame_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NBITS = 19;
  localparam int NVEC = 6;
  localparam logic [15:0] VEC [NVEC] = '{
    16'hA5_07, 16'h00_07, 16'hFF_31, 16'h3C_1D, 16'h81_9B, 16'h5A_D5
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_i = 1'b0;
  logic [7:0] data_i = '0;
  logic [7:0] divisor_i = '0;
  logic shift_i = 1'b0;
  logic tx_o, busy_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .data_i(data_i),
    .divisor_i(divisor_i), .shift_i(shift_i), .tx_o(tx_o), .busy_o(busy_o)
  );

  function automatic logic [7:0] ref_crc(input logic [7:0] d, input logic [7:0] v);
    logic [15:0] dv;
    dv = {d, 8'h00};
    for (int i = 15; i >= 8; i--)
      if (dv[i]) dv[i -: 9] = dv[i -: 9] ^ {1'b1, v};
    return dv[7:0];
  endfunction

  function automatic logic ref_bit(input logic [7:0] d, input logic [7:0] v, input int k);
    logic [7:0] c;
    c = ref_crc(d, v);
    if (k == 0) return 1'b0;
    if (k <= 8) return d[k-1];
    if (k == 9) return ^d;
    if (k <= 17) return c[17-k];
    return 1'b1;
  endfunction

  function automatic string tag_of(input int k);
    if (k == 0) return "R3";
    if (k <= 8) return "R4";
    if (k == 9) return "R5";
    if (k <= 17) return "R6";
    return "R7";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) shift_i = 1'b1;
    @(negedge clk) shift_i = 1'b0;
  endtask

  task automatic start(input logic [7:0] d, input logic [7:0] v);
    @(negedge clk) begin data_i = d; divisor_i = v; load_i = 1'b1; end
    @(negedge clk) load_i = 1'b0;
    check("R2 busy after load", busy_o, 1'b1);
    @(negedge clk);
  endtask

  task automatic finish_frame();
    tick();
    check("R8 busy cleared after tick 20", busy_o, 1'b0);
    check("R8 line high at end", tx_o, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset tx", tx_o, 1'b1);
    check("R1 reset busy", busy_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: idle ticks do nothing
    tick(); tick();
    check("R11 idle tick tx", tx_o, 1'b1);
    check("R11 idle tick busy", busy_o, 1'b0);

    for (int n = 0; n < NVEC; n++) begin
      logic [7:0] d, v;
      d = VEC[n][15:8];
      v = VEC[n][7:0];
      start(d, v);
      for (int k = 0; k < NBITS; k++) begin
        tick();
        check(tag_of(k), tx_o, ref_bit(d, v, k));
      end
      check("R8 busy through stop bit", busy_o, 1'b1);
      finish_frame();
    end

    // R3: tick in the capture cycle is ignored
    @(negedge clk) begin data_i = 8'hC3; divisor_i = 8'h07; load_i = 1'b1; end
    @(negedge clk) begin load_i = 1'b0; shift_i = 1'b1; end
    @(negedge clk) shift_i = 1'b0;
    check("R3 early tick ignored", tx_o, 1'b1);
    for (int k = 0; k < NBITS; k++) begin
      tick();
      check(tag_of(k), tx_o, ref_bit(8'hC3, 8'h07, k));
    end
    finish_frame();

    // R9 / R10: reload and divisor change mid-frame, R11 stability without ticks
    start(8'h6E, 8'h1D);
    for (int k = 0; k < NBITS; k++) begin
      if (k == 5) begin
        @(negedge clk) begin data_i = 8'h11; divisor_i = 8'hE2; load_i = 1'b1; end
        @(negedge clk) load_i = 1'b0;
        repeat (4) @(negedge clk);
        check("R11 tx stable without tick", tx_o, ref_bit(8'h6E, 8'h1D, 4));
      end
      tick();
      check(k >= 10 ? "R10 crc uses captured divisor" : "R9 frame unchanged",
            tx_o, ref_bit(8'h6E, 8'h1D, k));
    end
    // R9: load together with the final tick
    @(negedge clk) begin shift_i = 1'b1; load_i = 1'b1; data_i = 8'h00; end
    @(negedge clk) begin shift_i = 1'b0; load_i = 1'b0; end
    check("R9 busy falls despite load", busy_o, 1'b0);
    tick(); tick();
    check("R9 no frame started", tx_o, 1'b1);
    check("R9 still idle", busy_o, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule